// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block tracks loads that a compiler hoisted above stores which might write the same memory. When such a load issues early, it records its destination register tag and the byte range it read. Every later store is compared against all recorded ranges, and any entry whose range overlaps the store is dropped. At the original program point of the load, a check request by register tag asks whether the recorded entry survived. A surviving entry means the early value is still good. A missing entry means the speculation failed, and the block raises a reload request so that the load is executed again at that point. The memory access and the reload are done outside the block.

The table holds 32 entries as 16 sets of 2 ways. The set is chosen by the low 4 bits of the register tag, and the whole tag is stored for matching. A new load to a tag that is already present overwrites its entry. A load into a full set replaces the way that was allocated longest ago. A check for the load it pushed out then misses, which is the safe outcome.

Top module: `spec_ld_table`

## Requirements
- R1: After reset no entry is valid, so any check reports a miss with a reload request. While reset is held, `chk_done`, `chk_hit` and `reload_req` are low.
- R2: A check presented on `chk_valid` in cycle N sets `chk_done` high in cycle N+1 only. In that cycle exactly one of `chk_hit` and `reload_req` is high. When `chk_done` is low, both are low.
- R3: A speculative load records its tag and byte range, and a check for that tag in any later cycle hits as long as no overlapping store and no eviction has come in between.
- R4: The set is given by tag bits [3:0], and the full 7-bit tag is compared. A check for a tag that shares only the low 4 bits with a recorded tag misses.
- R5: The size code `sz` selects an access of 2**sz bytes (0=1, 1=2, 2=4, 3=8), covering addr to addr+2**sz-1. A store whose range overlaps an entry's range invalidates that entry. A store whose range only touches an entry's range without overlapping leaves the entry valid.
- R6: Within one cycle, a check sees the table as it stood before that cycle's load and store. A store takes effect before a load presented in the same cycle, so that load's new entry is not invalidated by it.
- R7: A load of a new tag into a set with both ways valid replaces the way allocated least recently. Re-loading a tag that is present makes it the most recently allocated. A way freed by a store is filled before any valid way is replaced.
- R8: A load to a tag that is already present overwrites that entry's range instead of creating a second entry. After that, stores to the old range no longer affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Speculative load issued this cycle |
| ld_tag | input | TAG_W (7) | Destination register tag of the load |
| ld_addr | input | ADDR_W (32) | Load start byte address |
| ld_sz | input | 2 | Load size code, 2**sz bytes |
| st_valid | input | 1 | Store issued this cycle |
| st_addr | input | ADDR_W (32) | Store start byte address |
| st_sz | input | 2 | Store size code, 2**sz bytes |
| chk_valid | input | 1 | Check request this cycle |
| chk_tag | input | TAG_W (7) | Register tag being checked |
| chk_done | output | 1 | Check result valid (one cycle after request) |
| chk_hit | output | 1 | Speculation still valid |
| reload_req | output | 1 | Speculation failed, reload at the check point |

## Verification
A wrong valid bit, a wrong stored range or a wrong age pointer inside a set stays hidden until a check addresses that set. It then shows as a flipped `chk_hit`/`reload_req` pair one cycle after the check. A wrong age pointer is harder to see: it shows only after a third distinct tag enters a full set and the surviving tag is then checked. The bench therefore issues dense checks on a small tag and address range, so that collisions and evictions come up often. It compares every result against a queue model that orders each set by allocation age.

// File: rtl/spec_ld_pkg.sv
package spec_ld_pkg;
  localparam int WAYS = 2;
  localparam int SZ_W = 2;

  // Access width in bytes for a size code: 1, 2, 4 or 8.
  function automatic logic [3:0] sz_bytes(input logic [SZ_W-1:0] sz);
    return 4'd1 << sz;
  endfunction
endpackage

// File: rtl/spec_ld_range_cmp.sv
module spec_ld_range_cmp #(
  parameter int AW = 32
) (
  input  logic [AW:0] a_lo,
  input  logic [AW:0] a_hi,
  input  logic [AW:0] b_lo,
  input  logic [AW:0] b_hi,
  output logic        overlap
);
  // Inclusive ranges; one extra bit keeps the end address from wrapping.
  assign overlap = (a_lo <= b_hi) && (b_lo <= a_hi);
endmodule

// File: rtl/spec_ld_set.sv
module spec_ld_set
  import spec_ld_pkg::*;
#(
  parameter int TAG_W = 7,
  parameter int AW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [TAG_W-1:0] ld_tag,
  input  logic [AW:0]      ld_lo,
  input  logic [AW:0]      ld_hi,
  input  logic             st_en,
  input  logic [AW:0]      st_lo,
  input  logic [AW:0]      st_hi,
  input  logic [TAG_W-1:0] look_tag,
  output logic             look_hit
);
  logic [WAYS-1:0]  vld_q, vld_n;
  logic [WAYS-1:0]  ovl, keep, same_tag, look_m;
  logic [TAG_W-1:0] tag_q [WAYS];
  logic [AW:0]      lo_q  [WAYS];
  logic [AW:0]      hi_q  [WAYS];
  logic             old_q, old_n;   // way allocated least recently
  logic             way_sel;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    spec_ld_range_cmp #(.AW(AW)) u_cmp (
      .a_lo   (lo_q[w]),
      .a_hi   (hi_q[w]),
      .b_lo   (st_lo),
      .b_hi   (st_hi),
      .overlap(ovl[w])
    );
    assign keep[w]     = vld_q[w] & ~(st_en & ovl[w]);
    assign same_tag[w] = keep[w] && (tag_q[w] == ld_tag);
    assign look_m[w]   = vld_q[w] && (tag_q[w] == look_tag);
  end

  assign look_hit = |look_m;

  // Way choice: existing tag, then a free way, then the oldest way.
  always_comb begin
    if (|same_tag)     way_sel = same_tag[1];
    else if (!keep[0]) way_sel = 1'b0;
    else if (!keep[1]) way_sel = 1'b1;
    else               way_sel = old_q;
  end

  always_comb begin
    vld_n = keep;
    old_n = old_q;
    if (alloc_en) begin
      vld_n[way_sel] = 1'b1;
      old_n          = ~way_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      old_q <= 1'b0;
    end else begin
      vld_q <= vld_n;
      old_q <= old_n;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      tag_q[way_sel] <= ld_tag;
      lo_q[way_sel]  <= ld_lo;
      hi_q[way_sel]  <= ld_hi;
    end
  end
endmodule

// File: rtl/spec_ld_table.sv
module spec_ld_table
  import spec_ld_pkg::*;
#(
  parameter int TAG_W  = 7,
  parameter int ADDR_W = 32,
  parameter int SETS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [1:0]        ld_sz,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_sz,
  input  logic              chk_valid,
  input  logic [TAG_W-1:0]  chk_tag,
  output logic              chk_done,
  output logic              chk_hit,
  output logic              reload_req
);
  localparam int IDX_W = $clog2(SETS);
  localparam int PAD_W = ADDR_W - 3;

  logic [ADDR_W:0]  ld_lo, ld_hi, st_lo, st_hi;
  logic [SETS-1:0]  set_hit;
  logic [IDX_W-1:0] ld_idx, chk_idx;
  logic             done_n, hit_n, rel_n;

  assign ld_idx  = ld_tag[IDX_W-1:0];
  assign chk_idx = chk_tag[IDX_W-1:0];
  assign ld_lo   = {1'b0, ld_addr};
  assign st_lo   = {1'b0, st_addr};
  assign ld_hi   = ld_lo + {{PAD_W{1'b0}}, sz_bytes(ld_sz)} - (ADDR_W+1)'(1);
  assign st_hi   = st_lo + {{PAD_W{1'b0}}, sz_bytes(st_sz)} - (ADDR_W+1)'(1);

  for (genvar s = 0; s < SETS; s++) begin : g_set
    spec_ld_set #(.TAG_W(TAG_W), .AW(ADDR_W)) u_set (
      .clk     (clk),
      .rst_n   (rst_n),
      .alloc_en(ld_valid && (ld_idx == IDX_W'(s))),
      .ld_tag  (ld_tag),
      .ld_lo   (ld_lo),
      .ld_hi   (ld_hi),
      .st_en   (st_valid),
      .st_lo   (st_lo),
      .st_hi   (st_hi),
      .look_tag(chk_tag),
      .look_hit(set_hit[s])
    );
  end

  always_comb begin
    done_n = chk_valid;
    hit_n  = chk_valid &  set_hit[chk_idx];
    rel_n  = chk_valid & ~set_hit[chk_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_done   <= 1'b0;
      chk_hit    <= 1'b0;
      reload_req <= 1'b0;
    end else begin
      chk_done   <= done_n;
      chk_hit    <= hit_n;
      reload_req <= rel_n;
    end
  end
endmodule

// File: rtl/spec_ld_table_chk.sv
module spec_ld_table_chk #(
  parameter int TAG_W  = 7,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic [TAG_W-1:0]  ld_tag,
  input logic              chk_valid,
  input logic [TAG_W-1:0]  chk_tag,
  input logic              chk_done,
  input logic              chk_hit,
  input logic              reload_req
);
  p_done_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid |=> chk_done);

  p_no_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_valid |=> !chk_done);

  p_one_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_done |-> (chk_hit ^ reload_req));

  p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_done |-> (!chk_hit && !reload_req));

  p_fresh_load_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ld_valid) && chk_valid && (chk_tag == $past(ld_tag)))
      |=> chk_hit);

  always @(posedge clk)
    if (!rst_n) a_reset_quiet_r1: assert (!chk_done || !chk_hit);
endmodule

bind spec_ld_table spec_ld_table_chk #(.TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_valid  (ld_valid),
  .ld_tag    (ld_tag),
  .chk_valid (chk_valid),
  .chk_tag   (chk_tag),
  .chk_done  (chk_done),
  .chk_hit   (chk_hit),
  .reload_req(reload_req)
);

// File: tb/spec_ld_table_test.sv
module spec_ld_table_test;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 7;
  localparam int AW    = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ld_valid, st_valid, chk_valid;
  logic [TAG_W-1:0] ld_tag, chk_tag;
  logic [AW-1:0] ld_addr, st_addr;
  logic [1:0]    ld_sz, st_sz;
  logic          chk_done, chk_hit, reload_req;

  int errors = 0;
  int checks = 0;

  typedef struct { int tag; longint lo; longint hi; } ent_t;
  ent_t model [16][$];   // per set, front = least recently allocated

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_ld_table uut (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr), .ld_sz(ld_sz),
    .st_valid(st_valid), .st_addr(st_addr), .st_sz(st_sz),
    .chk_valid(chk_valid), .chk_tag(chk_tag),
    .chk_done(chk_done), .chk_hit(chk_hit), .reload_req(reload_req)
  );

  function automatic bit model_has(int tag);
    foreach (model[tag % 16][i]) if (model[tag % 16][i].tag == tag) return 1'b1;
    return 1'b0;
  endfunction

  task automatic expect3(string req, bit ed, bit eh, bit er);
    checks++;
    if (chk_done !== ed || chk_hit !== eh || reload_req !== er) begin
      errors++;
      $display("FAIL %s: done/hit/reload actual=%b%b%b expected=%b%b%b",
               req, chk_done, chk_hit, reload_req, ed, eh, er);
    end
  endtask

  // One clock: drive, predict from the model, update the model, compare.
  task automatic step(string req, bit lv, int lt, longint la, int ls,
                      bit sv, longint sa, int ss, bit cv, int ct);
    bit eh;
    ld_valid = lv; ld_tag = TAG_W'(lt); ld_addr = AW'(la); ld_sz = 2'(ls);
    st_valid = sv; st_addr = AW'(sa); st_sz = 2'(ss);
    chk_valid = cv; chk_tag = TAG_W'(ct);
    eh = cv && model_has(ct);
    if (sv) begin
      longint shi = sa + (64'd1 << ss) - 1;
      for (int s = 0; s < 16; s++)
        for (int i = model[s].size() - 1; i >= 0; i--)
          if (model[s][i].lo <= shi && sa <= model[s][i].hi) model[s].delete(i);
    end
    if (lv) begin
      int s = lt % 16;
      ent_t e;
      e.tag = lt; e.lo = la; e.hi = la + (64'd1 << ls) - 1;
      for (int i = model[s].size() - 1; i >= 0; i--)
        if (model[s][i].tag == lt) model[s].delete(i);
      if (model[s].size() >= 2) void'(model[s].pop_front());
      model[s].push_back(e);
    end
    @(posedge clk);
    #1;
    expect3(req, cv, eh, cv && !eh);
  endtask

  task automatic idle();
    step("R2", 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ld_valid = 0; st_valid = 0; chk_valid = 1;
    ld_tag = '0; chk_tag = 5; ld_addr = '0; st_addr = '0; ld_sz = '0; st_sz = '0;
    repeat (3) @(posedge clk);
    #1;
    expect3("R1 outputs in reset", 0, 0, 0);
    rst_n = 1'b1;
    // R1: empty table after reset
    step("R1 check after reset", 0, 0, 0, 0, 0, 0, 0, 1, 5);
    idle();
    // R3: load then check
    step("R3 load", 1, 5, 'h100, 2, 0, 0, 0, 0, 0);
    step("R3 check hit", 0, 0, 0, 0, 0, 0, 0, 1, 5);
    // R4: same set, different upper tag bits
    step("R4 alias tag miss", 0, 0, 0, 0, 0, 0, 0, 1, 21);
    // R5: adjacent store leaves entry, overlapping store kills it
    step("R5 adjacent store", 0, 0, 0, 0, 1, 'h104, 0, 0, 0);
    step("R5 still hit", 0, 0, 0, 0, 0, 0, 0, 1, 5);
    step("R5 overlap store", 0, 0, 0, 0, 1, 'hFE, 2, 0, 0);
    step("R5 miss after overlap", 0, 0, 0, 0, 0, 0, 0, 1, 5);
    // R6: same-cycle ordering
    step("R6 load with check", 1, 7, 'h180, 3, 0, 0, 0, 1, 7);
    step("R6 next cycle hit", 0, 0, 0, 0, 0, 0, 0, 1, 7);
    step("R6 store with check", 0, 0, 0, 0, 1, 'h180, 0, 1, 7);
    step("R6 miss after store", 0, 0, 0, 0, 0, 0, 0, 1, 7);
    step("R6 load with store", 1, 8, 'h200, 1, 1, 'h200, 0, 0, 0);
    step("R6 load survives", 0, 0, 0, 0, 0, 0, 0, 1, 8);
    // R7: replacement order
    step("R7 fill a", 1, 3, 'h300, 0, 0, 0, 0, 0, 0);
    step("R7 fill b", 1, 19, 'h310, 0, 0, 0, 0, 0, 0);
    step("R7 evict a", 1, 35, 'h320, 0, 0, 0, 0, 0, 0);
    step("R7 a gone", 0, 0, 0, 0, 0, 0, 0, 1, 3);
    step("R7 b kept", 0, 0, 0, 0, 0, 0, 0, 1, 19);
    step("R7 refresh b", 1, 19, 'h310, 0, 0, 0, 0, 1, 35);
    step("R7 evict c", 1, 51, 'h330, 0, 0, 0, 0, 0, 0);
    step("R7 c gone", 0, 0, 0, 0, 0, 0, 0, 1, 35);
    step("R7 b after refresh", 0, 0, 0, 0, 0, 0, 0, 1, 19);
    step("R7 free way", 0, 0, 0, 0, 1, 'h330, 0, 0, 0);
    step("R7 fill free", 1, 67, 'h340, 0, 0, 0, 0, 0, 0);
    step("R7 b kept again", 0, 0, 0, 0, 0, 0, 0, 1, 19);
    // R8: same tag overwrites
    step("R8 first", 1, 9, 'h400, 2, 0, 0, 0, 0, 0);
    step("R8 overwrite", 1, 9, 'h500, 2, 0, 0, 0, 0, 0);
    step("R8 old range store", 0, 0, 0, 0, 1, 'h400, 3, 0, 0);
    step("R8 still hit", 0, 0, 0, 0, 0, 0, 0, 1, 9);
    step("R8 new range store", 0, 0, 0, 0, 1, 'h503, 0, 0, 0);
    step("R8 miss", 0, 0, 0, 0, 0, 0, 0, 1, 9);
    // Mixed traffic, dense collisions
    for (int n = 0; n < 3000; n++) begin
      step("R5/R7 mixed",
           ($urandom % 2) == 0, int'($urandom % 48), 'h1000 + longint'($urandom % 64), int'($urandom % 4),
           ($urandom % 3) == 0, 'h1000 + longint'($urandom % 64), int'($urandom % 4),
           ($urandom % 2) == 0, int'($urandom % 48));
    end
    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule